// File: doc/BRIEF.md
# Multi-Lane Serial Master Transmitter

This block is the send side of a serial master for flash-style devices. It moves characters out on one, two or four data lanes, with a serial clock it generates itself. Software writes a character into a single holding register. The block copies it into a shift register as soon as the shifter is free, and then pulses the serial clock a programmed number of times. On each rising clock edge it puts the next group of bits on the active lanes.

A new character can be written while the previous one is still shifting, as long as the holding register is empty. The next character then starts with no idle gap. When the last clock of a character ends and nothing is waiting, the clock parks low and an end-of-transmission flag is raised.

The chip select comes straight from a control input. Each of the two status flags has its own interrupt enable. A direction control decides whether the lanes are driven in the multi-lane modes.

Top module: `qspi_tx_master`

## Requirements
- R1: A write on `txd_wr` is accepted only while `tbe_flag` is 1. Accepting it clears `tbe_flag`. A write made while `tbe_flag` is 0 is ignored, and its data is never sent.
- R2: When the held character moves into the shifter, `tbe_flag` returns to 1. `tbe_irq` equals `tbe_flag` AND `tbe_ie`. After reset, `tbe_flag` is 1.
- R3: Each character produces exactly `char_len`+1 clock pulses on `sclk`. A pulse is high for PRESCALE system cycles and then low for PRESCALE cycles. `sclk` is low whenever no character is shifting.
- R4: Lane modes are set by `xfer_mode`:
  - 00 is single: lane 0 only.
  - 01 is dual: lanes 1:0, with lane 1 carrying the more significant bit.
  - 10 is quad: lanes 3:0, with lane 3 carrying the most significant bit.
  - 11 behaves as single.
  
  A character is the low (`char_len`+1)×lanes bits of `txd_data`, sent most significant bits first. Lanes are updated together with each rising `sclk` edge.
- R5: A character written while a previous one is shifting starts immediately after it. The low phase between the two characters is exactly PRESCALE cycles, the same as within a character.
- R6: When a character ends and no character is waiting, `sclk` stays low and `tend_flag` sets. `tend_irq` equals `tend_flag` AND `tend_ie`.
- R7: In dual or quad mode, `lane_oe` shows the mode's lane mask while a character is shifting and `lane_dir` is 0, and is all zero otherwise. In single mode, `lane_oe` is 0001 whatever the value of `lane_dir`.
- R8: Pulsing `tend_clr` clears `tend_flag` on the next cycle. If a new end event happens in the same cycle, setting the flag takes priority over clearing it.
- R9: `ss_n` is the inverse of `ss_ctl`, registered one cycle later. After reset, `ss_n` is 1.
- R10: After reset, `sclk`, `lane_out`, `tend_flag` and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txd_wr | input | 1 | Write strobe for the holding register |
| txd_data | input | DATA_W | Character data, right-aligned |
| char_len | input | LEN_W | Clock pulses per character minus one |
| xfer_mode | input | 2 | Lane mode: 00 single, 01 dual, 10 quad |
| lane_dir | input | 1 | 1 disables lane drive in multi-lane modes |
| ss_ctl | input | 1 | Chip select request, active high |
| tbe_ie | input | 1 | Buffer-empty interrupt enable |
| tend_ie | input | 1 | End-of-transmission interrupt enable |
| tend_clr | input | 1 | Clears the end-of-transmission flag |
| sclk | output | 1 | Serial clock, idles low |
| ss_n | output | 1 | Chip select, active low |
| lane_out | output | 4 | Lane data |
| lane_oe | output | 4 | Per-lane output enable |
| tbe_flag | output | 1 | Holding register empty |
| tend_flag | output | 1 | Transmission ended |
| tbe_irq | output | 1 | Buffer-empty interrupt |
| tend_irq | output | 1 | End-of-transmission interrupt |

## Verification
The bench tests three kinds of input.

Single isolated characters cover every lane mode and several lengths, including the shortest and the longest. They show whether bit order, lane assignment and pulse count are right.

Back-to-back pairs, written as soon as the buffer flag rises, show whether the low phase between characters stretches. A third write into a full buffer shows whether rejected data leaks onto the lanes.

Random characters, with random mode and length, cover the combinations in between. Direction and mode are swept to tell the enable mask of single mode apart from the masks of the multi-lane modes.

// File: rtl/qspi_tx_pkg.sv
package qspi_tx_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_DUAL   = 2'b01,
    MODE_QUAD   = 2'b10,
    MODE_ALT1   = 2'b11
  } xfer_mode_e;

  function automatic int unsigned lanes_of(input logic [1:0] m);
    case (m)
      MODE_DUAL: return 2;
      MODE_QUAD: return 4;
      default:   return 1;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] m);
    case (m)
      MODE_DUAL: return 4'b0011;
      MODE_QUAD: return 4'b1111;
      default:   return 4'b0001;
    endcase
  endfunction

  function automatic bit is_multi(input logic [1:0] m);
    return (m == MODE_DUAL) || (m == MODE_QUAD);
  endfunction

endpackage

// File: rtl/qspi_tx_holdreg.sv
module qspi_tx_holdreg #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] dout
);
  logic accept;
  assign accept = wr && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else begin
      if (take)        full <= 1'b0;
      else if (accept) full <= 1'b1;
      if (accept) dout <= din;
    end
  end
endmodule

// File: rtl/qspi_tx_seq.sv
module qspi_tx_seq #(
  parameter int PRESCALE = 2,
  parameter int LEN_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buf_full,
  input  logic [LEN_W-1:0] char_len,
  output logic             busy,
  output logic             sclk,
  output logic             ev_load,
  output logic             ev_shift,
  output logic             ev_char_done,
  output logic             ev_end
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] HALF_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0]    pre_cnt;
  logic [LEN_W-1:0] left_q;
  logic             half_done;

  assign half_done    = busy && (pre_cnt == HALF_LAST);
  assign ev_char_done = half_done && !sclk && (left_q == '0);
  assign ev_shift     = half_done && !sclk && (left_q != '0);
  assign ev_load      = (!busy || ev_char_done) && buf_full;
  assign ev_end       = ev_char_done && !buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      pre_cnt <= '0;
      left_q  <= '0;
    end else if (ev_load) begin
      busy    <= 1'b1;
      sclk    <= 1'b1;
      pre_cnt <= '0;
      left_q  <= char_len;
    end else if (ev_end) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      pre_cnt <= '0;
    end else if (busy) begin
      if (half_done) begin
        pre_cnt <= '0;
        sclk    <= !sclk;
        if (ev_shift) left_q <= left_q - 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/qspi_tx_shifter.sv
module qspi_tx_shifter
  import qspi_tx_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_load,
  input  logic              ev_shift,
  input  logic              busy,
  input  logic [DATA_W-1:0] din,
  input  logic [LEN_W-1:0]  char_len,
  input  logic [1:0]        mode_in,
  input  logic              dir,
  output logic [3:0]        lane_out,
  output logic [3:0]        lane_oe
);
  logic [DATA_W-1:0] sh;
  logic [1:0]        mode_q;
  logic [1:0]        eff_mode;

  function automatic logic [DATA_W-1:0] left_align(input logic [DATA_W-1:0] d,
                                                   input logic [LEN_W-1:0] len,
                                                   input logic [1:0] m);
    int nb;
    nb = (int'(len) + 1) * int'(lanes_of(m));
    if (nb >= DATA_W) return d;
    return d << (DATA_W - nb);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      mode_q <= MODE_SINGLE;
    end else if (ev_load) begin
      sh     <= left_align(din, char_len, mode_in);
      mode_q <= mode_in;
    end else if (ev_shift) begin
      sh <= sh << lanes_of(mode_q);
    end
  end

  assign eff_mode = busy ? mode_q : mode_in;

  always_comb begin
    lane_out = 4'b0000;
    if (busy) begin
      case (mode_q)
        MODE_QUAD: lane_out = sh[DATA_W-1 -: 4];
        MODE_DUAL: lane_out = {2'b00, sh[DATA_W-1 -: 2]};
        default:   lane_out = {3'b000, sh[DATA_W-1]};
      endcase
    end
  end

  always_comb begin
    if (!is_multi(eff_mode))   lane_oe = 4'b0001;
    else if (busy && !dir)     lane_oe = lane_mask(eff_mode);
    else                       lane_oe = 4'b0000;
  end
endmodule

// File: rtl/qspi_tx_master.sv
module qspi_tx_master #(
  parameter int DATA_W   = 64,
  parameter int LEN_W    = 4,
  parameter int PRESCALE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txd_wr,
  input  logic [DATA_W-1:0] txd_data,
  input  logic [LEN_W-1:0]  char_len,
  input  logic [1:0]        xfer_mode,
  input  logic              lane_dir,
  input  logic              ss_ctl,
  input  logic              tbe_ie,
  input  logic              tend_ie,
  input  logic              tend_clr,
  output logic              sclk,
  output logic              ss_n,
  output logic [3:0]        lane_out,
  output logic [3:0]        lane_oe,
  output logic              tbe_flag,
  output logic              tend_flag,
  output logic              tbe_irq,
  output logic              tend_irq
);
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;
  logic              busy;
  logic              ev_load;
  logic              ev_shift;
  logic              ev_char_done;
  logic              ev_end;

  qspi_tx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr(txd_wr), .din(txd_data),
    .take(ev_load), .full(buf_full), .dout(buf_data)
  );

  qspi_tx_seq #(.PRESCALE(PRESCALE), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .buf_full(buf_full), .char_len(char_len),
    .busy(busy), .sclk(sclk), .ev_load(ev_load), .ev_shift(ev_shift),
    .ev_char_done(ev_char_done), .ev_end(ev_end)
  );

  qspi_tx_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .ev_load(ev_load), .ev_shift(ev_shift),
    .busy(busy), .din(buf_data), .char_len(char_len), .mode_in(xfer_mode),
    .dir(lane_dir), .lane_out(lane_out), .lane_oe(lane_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend_flag <= 1'b0;
      ss_n      <= 1'b1;
    end else begin
      if (ev_end)        tend_flag <= 1'b1;
      else if (tend_clr) tend_flag <= 1'b0;
      ss_n <= !ss_ctl;
    end
  end

  assign tbe_flag = !buf_full;
  assign tbe_irq  = tbe_flag && tbe_ie;
  assign tend_irq = tend_flag && tend_ie;
endmodule

// File: rtl/qspi_tx_checker.sv
module qspi_tx_checker #(
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_load,
  input logic             ev_shift,
  input logic             ev_char_done,
  input logic             ev_end,
  input logic             busy,
  input logic             sclk,
  input logic             ss_ctl,
  input logic             ss_n,
  input logic             lane_dir,
  input logic [3:0]       lane_oe,
  input logic [LEN_W-1:0] char_len,
  input logic             tbe_flag,
  input logic             tbe_ie,
  input logic             tbe_irq,
  input logic             tend_flag,
  input logic             tend_ie,
  input logic             tend_irq,
  input logic             tend_clr
);
  logic [LEN_W:0]   pulse_cnt;
  logic [LEN_W-1:0] len_q;
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_cnt <= '0;
      len_q     <= '0;
      armed     <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (ev_load) begin
        pulse_cnt <= 1;
        len_q     <= char_len;
      end else if (ev_shift) begin
        pulse_cnt <= pulse_cnt + 1'b1;
      end
    end
  end

  // R2
  tbe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> tbe_flag);
  // R2
  tbe_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tbe_flag) && tbe_ie) |-> tbe_irq);
  // R3
  pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_char_done |-> (pulse_cnt == ({1'b0, len_q} + 1'b1)));
  // R3
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  // R6
  tend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> (tend_flag && !sclk));
  // R6
  tend_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tend_flag) && tend_ie) |-> tend_irq);
  // R7
  dir_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_dir |-> ((lane_oe == 4'b0000) || (lane_oe == 4'b0001)));
  // R8
  tend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tend_clr && !ev_end) |=> !tend_flag);
  // R9
  ss_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (ss_n == !$past(ss_ctl)));
endmodule

bind qspi_tx_master qspi_tx_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_load(ev_load), .ev_shift(ev_shift),
  .ev_char_done(ev_char_done), .ev_end(ev_end), .busy(busy), .sclk(sclk),
  .ss_ctl(ss_ctl), .ss_n(ss_n), .lane_dir(lane_dir), .lane_oe(lane_oe),
  .char_len(char_len), .tbe_flag(tbe_flag), .tbe_ie(tbe_ie), .tbe_irq(tbe_irq),
  .tend_flag(tend_flag), .tend_ie(tend_ie), .tend_irq(tend_irq), .tend_clr(tend_clr)
);

// File: tb/tb_qspi_tx_master.sv
module tb_qspi_tx_master;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 64;
  localparam int LEN_W = 4;
  localparam int PRESCALE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd_wr = 1'b0;
  logic [DATA_W-1:0] txd_data = '0;
  logic [LEN_W-1:0] char_len = '0;
  logic [1:0] xfer_mode = 2'b00;
  logic lane_dir = 1'b0, ss_ctl = 1'b0, tbe_ie = 1'b0, tend_ie = 1'b0, tend_clr = 1'b0;
  logic sclk, ss_n, tbe_flag, tend_flag, tbe_irq, tend_irq;
  logic [3:0] lane_out, lane_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [63:0] rx;
  int nclk, low_run, max_low;
  bit in_burst = 0, sclk_p = 0;
  logic [3:0] oe_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  qspi_tx_master #(.DATA_W(DATA_W), .LEN_W(LEN_W), .PRESCALE(PRESCALE)) dut (
    .clk(clk), .rst_n(rst_n), .txd_wr(txd_wr), .txd_data(txd_data),
    .char_len(char_len), .xfer_mode(xfer_mode), .lane_dir(lane_dir),
    .ss_ctl(ss_ctl), .tbe_ie(tbe_ie), .tend_ie(tend_ie), .tend_clr(tend_clr),
    .sclk(sclk), .ss_n(ss_n), .lane_out(lane_out), .lane_oe(lane_oe),
    .tbe_flag(tbe_flag), .tend_flag(tend_flag), .tbe_irq(tbe_irq), .tend_irq(tend_irq)
  );

  function automatic int lanes_for(input logic [1:0] m);
    if (m == 2'b01) return 2;
    if (m == 2'b10) return 4;
    return 1;
  endfunction

  function automatic logic [63:0] expect_bits(input logic [63:0] d, input int len, input logic [1:0] m);
    int nb;
    nb = (len + 1) * lanes_for(m);
    if (nb >= 64) return d;
    return d & ((64'd1 << nb) - 64'd1);
  endfunction

  function automatic logic [3:0] expect_mask(input logic [1:0] m);
    if (m == 2'b01) return 4'b0011;
    if (m == 2'b10) return 4'b1111;
    return 4'b0001;
  endfunction

  always @(negedge clk) begin
    if (sclk && !sclk_p) begin
      case (xfer_mode)
        2'b10:   rx = (rx << 4) | {60'd0, lane_out};
        2'b01:   rx = (rx << 2) | {62'd0, lane_out[1:0]};
        default: rx = (rx << 1) | {63'd0, lane_out[0]};
      endcase
      if (nclk > 0 && low_run > max_low) max_low = low_run;
      nclk++;
      low_run = 0;
      oe_seen = lane_oe;
    end else if (!sclk && in_burst) begin
      low_run++;
    end
    sclk_p = sclk;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_char(input logic [63:0] d);
    @(negedge clk);
    txd_wr = 1'b1;
    txd_data = d;
    @(negedge clk);
    txd_wr = 1'b0;
  endtask

  task automatic start_burst(input int len, input logic [1:0] m);
    @(negedge clk);
    char_len = LEN_W'(len);
    xfer_mode = m;
    rx = '0;
    nclk = 0;
    low_run = 0;
    max_low = 0;
    oe_seen = '0;
    in_burst = 1;
  endtask

  task automatic wait_end();
    int t;
    t = 0;
    while (!tend_flag && t < 3000) begin
      @(negedge clk);
      t++;
    end
    in_burst = 0;
    chk(tend_flag == 1'b1, "R6 end flag", {63'd0, tend_flag}, 64'd1);
    chk(sclk == 1'b0, "R6 clock parked low", {63'd0, sclk}, 64'd0);
  endtask

  task automatic clear_end();
    @(negedge clk);
    tend_clr = 1'b1;
    @(negedge clk);
    tend_clr = 1'b0;
    chk(tend_flag == 1'b0, "R8 flag cleared", {63'd0, tend_flag}, 64'd0);
  endtask

  task automatic send_one(input logic [63:0] d, input int len, input logic [1:0] m);
    start_burst(len, m);
    write_char(d);
    wait_end();
    chk(rx == expect_bits(d, len, m), "R4 lane data", rx, expect_bits(d, len, m));
    chk(nclk == len + 1, "R3 pulse count", 64'(nclk), 64'(len + 1));
    clear_end();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 / R2 / R9 reset state
    chk(sclk == 0 && lane_out == 0, "R10 reset outputs", {59'd0, sclk, lane_out}, 64'd0);
    chk(tend_flag == 0 && tend_irq == 0 && tbe_irq == 0, "R10 reset flags", {61'd0, tend_flag, tend_irq, tbe_irq}, 64'd0);
    chk(tbe_flag == 1, "R2 reset buffer empty", {63'd0, tbe_flag}, 64'd1);
    chk(ss_n == 1, "R9 reset select", {63'd0, ss_n}, 64'd1);

    // R9 select follows
    @(negedge clk); ss_ctl = 1'b1;
    @(negedge clk);
    chk(ss_n == 0, "R9 select asserted", {63'd0, ss_n}, 64'd0);

    // R1 / R2 flag timing and interrupt
    tbe_ie = 1'b1;
    tend_ie = 1'b1;
    start_burst(7, 2'b00);
    @(negedge clk); txd_wr = 1'b1; txd_data = 64'hA5;
    @(negedge clk); txd_wr = 1'b0;
    chk(tbe_flag == 0 && tbe_irq == 0, "R1 write clears empty flag", {62'd0, tbe_flag, tbe_irq}, 64'd0);
    @(negedge clk);
    chk(tbe_flag == 1 && tbe_irq == 1, "R2 flag and irq on load", {62'd0, tbe_flag, tbe_irq}, 64'd3);
    chk(sclk == 1, "R3 clock starts after load", {63'd0, sclk}, 64'd1);
    wait_end();
    chk(tend_irq == 1, "R6 end irq", {63'd0, tend_irq}, 64'd1);
    chk(rx == 64'hA5, "R4 single byte", rx, 64'hA5);
    chk(nclk == 8 && max_low == PRESCALE, "R3 pulses and low phase", 64'(nclk), 64'd8);
    clear_end();

    // R4 quad with 4 pulses, R7 enables
    start_burst(3, 2'b10);
    write_char(64'h1234_C3E7);
    wait_end();
    chk(rx == 64'hC3E7, "R4 quad 16 bits", rx, 64'hC3E7);
    chk(nclk == 4, "R3 quad pulses", 64'(nclk), 64'd4);
    chk(oe_seen == 4'b1111, "R7 quad enables while shifting", {60'd0, oe_seen}, 64'hF);
    chk(lane_oe == 4'b0000, "R7 quad idle enables off", {60'd0, lane_oe}, 64'h0);
    clear_end();

    // R4 dual
    send_one(64'h9B6, 5, 2'b01);
    // R4 extremes
    send_one(64'h1, 0, 2'b00);
    send_one(64'hFEDC_BA98_7654_3210, 15, 2'b10);
    send_one(64'h5A5A, 15, 2'b11);

    // R7 direction in quad and single
    lane_dir = 1'b1;
    start_burst(1, 2'b10);
    write_char(64'hAB);
    wait_end();
    chk(oe_seen == 4'b0000, "R7 dir disables quad", {60'd0, oe_seen}, 64'h0);
    clear_end();
    start_burst(1, 2'b00);
    write_char(64'h2);
    wait_end();
    chk(oe_seen == 4'b0001 && lane_oe == 4'b0001, "R7 single ignores dir", {56'd0, oe_seen, lane_oe}, 64'h11);
    clear_end();
    lane_dir = 1'b0;

    // R5 back to back, R1 rejected third write
    start_burst(7, 2'b00);
    write_char(64'h3C);
    write_char(64'hC9);
    chk(tbe_flag == 0, "R1 second char held", {63'd0, tbe_flag}, 64'd0);
    write_char(64'hFF);
    wait_end();
    chk(rx == 64'h3CC9, "R1 rejected write not sent", rx, 64'h3CC9);
    chk(nclk == 16, "R5 two characters", 64'(nclk), 64'd16);
    chk(max_low == PRESCALE, "R5 no gap between characters", 64'(max_low), 64'(PRESCALE));
    clear_end();

    // R5 quad back to back written on buffer-empty
    start_burst(2, 2'b10);
    write_char(64'h123);
    while (!tbe_flag) @(negedge clk);
    write_char(64'h456);
    wait_end();
    chk(rx == 64'h123456, "R5 quad chain", rx, 64'h123456);
    chk(max_low == PRESCALE, "R5 quad chain gap", 64'(max_low), 64'(PRESCALE));
    clear_end();

    // R8 clear with no pending end
    @(negedge clk); tend_clr = 1'b1;
    @(negedge clk); tend_clr = 1'b0;
    chk(tend_flag == 0, "R8 clear idle", {63'd0, tend_flag}, 64'd0);

    // random characters
    for (int i = 0; i < 30; i++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      send_one(d, int'($urandom % 16), 2'($urandom % 4));
    end

    @(negedge clk); ss_ctl = 1'b0;
    @(negedge clk);
    chk(ss_n == 1, "R9 select released", {63'd0, ss_n}, 64'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule